// File: doc/BRIEF.md
# Link Packet Receive Demultiplexer

This block sits behind a serial transceiver that has already aligned its output to 16-bit words. It frames the word stream into packets, checks each packet's CRC-16 and steers the payload to one of two streaming outputs: bulk front-end data or slow-control traffic. Two start codes pick the destination, and both packet types close with the same end code. The last word before the end code carries the CRC.

Each output presents a valid strobe, the payload word, a last flag on the final beat and an error flag on the final beat. A saturating error counter and a sticky error flag report damaged packets. The receiver holds back two words so that it can tell the CRC word apart from payload. It forwards a payload word only when the stream shows that the word is not the CRC.

Top module: `pkt_rx_demux`

## Requirements
- R1: While reset is asserted and after reset, both valid outputs, both last and error flags, the error counter and the sticky flag are all zero.
- R2: While no packet is open, every accepted word other than a start code is dropped. This includes the end code 0x95FD. No output beat appears and the error counter does not change.
- R3: A packet opened by 0x95FB sends its payload words, in arrival order, to the data output. Each beat appears one clock after the input word two positions later in the stream is accepted.
- R4: A packet opened by 0x951C sends its payload to the slow-control output in the same way. The other output stays silent for the whole packet.
- R5: When the end code 0x95FD arrives, the word just before it is taken as the CRC and is not forwarded. The payload word before the CRC is output with the last flag set.
- R6: The CRC is CRC-16 with polynomial 0x1021 and seed 0xFFFF. It is fed MSB first, one 16-bit word at a time, over all payload words. On a mismatch the last beat carries error=1 and the counter rises by one. On a match the error flag is 0.
- R7: A start code that arrives inside an open packet aborts that packet. The oldest held word, if there is one, is emitted with last=1 and error=1, and the newest held word is dropped. The counter rises by one and a new packet of the type named by the new code begins.
- R8: An end code that arrives when fewer than two words have come in since the start code produces no beat and raises the counter by one.
- R9: The error counter saturates at 2^CNT_W-1. The sticky flag sets on the first error and stays set until reset.
- R10: Cycles with in_valid low have no effect, so gaps may fall anywhere inside a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 16 | Word from the transceiver |
| data_valid | output | 1 | Data output beat strobe |
| data_word | output | 16 | Data output payload word |
| data_last | output | 1 | Final beat of a data packet |
| data_err | output | 1 | Data packet failed CRC or was aborted (final beat only) |
| sc_valid | output | 1 | Slow-control output beat strobe |
| sc_word | output | 16 | Slow-control output payload word |
| sc_last | output | 1 | Final beat of a slow-control packet |
| sc_err | output | 1 | Slow-control packet failed CRC or was aborted (final beat only) |
| err_count | output | CNT_W | Saturating count of bad packets |
| err_sticky | output | 1 | Set on the first bad packet |

## Verification
The bench builds the block with CNT_W=3. With that setting the error counter reaches its ceiling of 7 partway through the packet sweep, so both the counting and the saturation are observed. The sweep covers payload lengths from 1 to 12 on both packet types, with good and corrupted CRCs and with and without idle gaps, and compares every beat against a CRC the bench computes itself. Directed cases cover idle discarding, short packets, aborts and the exact beat latency.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] SOP_DATA = 16'h95FB;
  localparam logic [WORD_W-1:0] SOP_SLOW = 16'h951C;
  localparam logic [WORD_W-1:0] EOP_CODE = 16'h95FD;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_SLOW} rx_state_e;

  // one word of CRC-16, most significant bit first
  function automatic logic [15:0] crc_step(input logic [15:0] acc,
                                           input logic [WORD_W-1:0] w);
    logic [15:0] c;
    c = acc;
    for (int b = WORD_W - 1; b >= 0; b--) begin
      if (c[15] ^ w[b]) c = (c << 1) ^ CRC_POLY;
      else              c = c << 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/rx_crc16.sv
module rx_crc16
  import pkt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [WORD_W-1:0] din,
  output logic [15:0]       crc_next
);
  logic [15:0] acc_q;

  always_comb crc_next = crc_step(acc_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= CRC_SEED;
    else if (clr) acc_q <= CRC_SEED;
    else if (en)  acc_q <= crc_next;
  end

  // R6: a new packet always starts from the seed
  a_r6_seed_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc_q == CRC_SEED));
endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import pkt_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [WORD_W-1:0] word,
  output logic              h0_vld,
  output logic [WORD_W-1:0] h0,
  output logic              h1_vld,
  output logic [WORD_W-1:0] h1
);
  logic h0_vld_d, h1_vld_d;

  always_comb begin
    h0_vld_d = h0_vld;
    h1_vld_d = h1_vld;
    if (flush) begin
      h0_vld_d = 1'b0;
      h1_vld_d = 1'b0;
    end else if (push) begin
      h0_vld_d = h1_vld;
      h1_vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h0_vld <= 1'b0;
      h1_vld <= 1'b0;
    end else begin
      h0_vld <= h0_vld_d;
      h1_vld <= h1_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      h0 <= h1;
      h1 <= word;
    end
  end

  // R5: the older slot is only filled through the newer one
  a_r5_hold_order: assert property (@(posedge clk) disable iff (!rst_n)
    h0_vld |-> h1_vld);
endmodule

// File: rtl/rx_err_cnt.sv
module rx_err_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             sticky
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] count_d;
  logic             sticky_d;

  always_comb begin
    count_d  = count;
    sticky_d = sticky | inc;
    if (inc && count != CNT_MAX) count_d = count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count  <= '0;
      sticky <= 1'b0;
    end else begin
      count  <= count_d;
      sticky <= sticky_d;
    end
  end

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));
  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count == $past(count)) || (count == $past(count) + 1'b1));
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sticky |=> sticky);
  a_r9_sticky_covers: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |-> sticky);
endmodule

// File: rtl/pkt_rx_demux.sv
module pkt_rx_demux
  import pkt_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              data_valid,
  output logic [WORD_W-1:0] data_word,
  output logic              data_last,
  output logic              data_err,
  output logic              sc_valid,
  output logic [WORD_W-1:0] sc_word,
  output logic              sc_last,
  output logic              sc_err,
  output logic [CNT_W-1:0]  err_count,
  output logic              err_sticky
);
  logic rst_sn;
  rx_state_e state_q, state_d;

  logic is_sop_d, is_sop_s, is_sop, is_eop;
  logic h0_vld, h1_vld;
  logic [WORD_W-1:0] h0, h1, word_q;
  logic [15:0] crc_next;
  logic emit_vld, emit_last, emit_err, emit_slow;
  logic hold_push, hold_flush, crc_clr, crc_en, err_inc;

  rx_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  assign is_sop_d = in_valid && (in_word == SOP_DATA);
  assign is_sop_s = in_valid && (in_word == SOP_SLOW);
  assign is_sop   = is_sop_d || is_sop_s;
  assign is_eop   = in_valid && (in_word == EOP_CODE);

  rx_hold i_hold (
    .clk(clk), .rst_n(rst_sn), .flush(hold_flush), .push(hold_push),
    .word(in_word), .h0_vld(h0_vld), .h0(h0), .h1_vld(h1_vld), .h1(h1)
  );

  rx_crc16 i_crc (
    .clk(clk), .rst_n(rst_sn), .clr(crc_clr), .en(crc_en),
    .din(h0), .crc_next(crc_next)
  );

  rx_err_cnt #(.CNT_W(CNT_W)) i_err (
    .clk(clk), .rst_n(rst_sn), .inc(err_inc),
    .count(err_count), .sticky(err_sticky)
  );

  // next-state and control
  always_comb begin
    state_d    = state_q;
    emit_vld   = 1'b0;
    emit_last  = 1'b0;
    emit_err   = 1'b0;
    hold_push  = 1'b0;
    hold_flush = 1'b0;
    crc_clr    = 1'b0;
    crc_en     = 1'b0;
    err_inc    = 1'b0;
    emit_slow  = (state_q == ST_SLOW);
    if (state_q == ST_IDLE) begin
      if (is_sop) begin
        state_d    = is_sop_d ? ST_DATA : ST_SLOW;
        hold_flush = 1'b1;
        crc_clr    = 1'b1;
      end
    end else if (is_sop) begin
      emit_vld   = h0_vld;
      emit_last  = 1'b1;
      emit_err   = 1'b1;
      err_inc    = 1'b1;
      hold_flush = 1'b1;
      crc_clr    = 1'b1;
      state_d    = is_sop_d ? ST_DATA : ST_SLOW;
    end else if (is_eop) begin
      if (h0_vld && h1_vld) begin
        emit_vld  = 1'b1;
        emit_last = 1'b1;
        emit_err  = (crc_next != h1);
        err_inc   = emit_err;
      end else begin
        err_inc = 1'b1;
      end
      hold_flush = 1'b1;
      crc_clr    = 1'b1;
      state_d    = ST_IDLE;
    end else if (in_valid) begin
      hold_push = 1'b1;
      if (h0_vld) begin
        emit_vld = 1'b1;
        crc_en   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= ST_IDLE;
      data_valid <= 1'b0;
      data_last  <= 1'b0;
      data_err   <= 1'b0;
      sc_valid   <= 1'b0;
      sc_last    <= 1'b0;
      sc_err     <= 1'b0;
    end else begin
      state_q    <= state_d;
      data_valid <= emit_vld && !emit_slow;
      data_last  <= emit_vld && !emit_slow && emit_last;
      data_err   <= emit_vld && !emit_slow && emit_err;
      sc_valid   <= emit_vld && emit_slow;
      sc_last    <= emit_vld && emit_slow && emit_last;
      sc_err     <= emit_vld && emit_slow && emit_err;
    end
  end

  always_ff @(posedge clk) begin
    if (emit_vld) word_q <= h0;
  end

  assign data_word = word_q;
  assign sc_word   = word_q;

  // R4: at most one destination per beat
  a_r4_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_valid && sc_valid));
  a_r6_err_on_last_data: assert property (@(posedge clk) disable iff (!rst_n)
    data_err |-> (data_valid && data_last));
  a_r6_err_on_last_sc: assert property (@(posedge clk) disable iff (!rst_n)
    sc_err |-> (sc_valid && sc_last));
  // R2: words outside a packet leave no trace at the outputs
  a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_IDLE && in_valid && !is_sop) |=> (!data_valid && !sc_valid));
  // R10: an idle input cycle produces no beat
  a_r10_no_beat_without_input: assert property (@(posedge clk) disable iff (!rst_sn)
    !in_valid |=> (!data_valid && !sc_valid));
endmodule

// File: tb/test_pkt_rx_demux.sv
module test_pkt_rx_demux;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 3;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_word = '0;
  logic data_valid, data_last, data_err, sc_valid, sc_last, sc_err, err_sticky;
  logic [15:0] data_word, sc_word;
  logic [CNT_W-1:0] err_count;

  int n_chk = 0;
  int n_bad = 0;
  int exp_err = 0;
  bit exp_sticky = 0;
  logic [17:0] dq[$];
  logic [17:0] sq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pkt_rx_demux #(.CNT_W(CNT_W)) i_pkt_rx_demux (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
    .data_valid(data_valid), .data_word(data_word), .data_last(data_last),
    .data_err(data_err), .sc_valid(sc_valid), .sc_word(sc_word),
    .sc_last(sc_last), .sc_err(sc_err), .err_count(err_count),
    .err_sticky(err_sticky)
  );

  always @(negedge clk) begin
    if (data_valid) dq.push_back({data_last, data_err, data_word});
    if (sc_valid)   sq.push_back({sc_last, sc_err, sc_word});
  end

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [15:0] w);
    logic [15:0] r;
    r = c;
    for (int k = 0; k < 16; k++) begin
      logic fb;
      fb = r[15] ^ w[15-k];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic note_err();
    exp_sticky = 1;
    if (exp_err < CNT_MAX) exp_err++;
  endtask

  task automatic chk_cnt(input string tag);
    chk(err_count == CNT_W'(exp_err) && err_sticky == exp_sticky, tag,
        {err_sticky, err_count}, {exp_sticky, CNT_W'(exp_err)});
  endtask

  task automatic run_pkt(input bit slow, input int len, input bit bad, input bit gapped);
    logic [15:0] pl[16];
    logic [15:0] c;
    bit ok_w, ok_l, ok_e;
    c = 16'hFFFF;
    dq.delete();
    sq.delete();
    for (int i = 0; i < len; i++) begin
      pl[i] = {slow ? 4'hA : 4'h3, 4'(len), 8'(i * 17 + 5)};
      c = ref_crc(c, pl[i]);
    end
    put(slow ? 16'h951C : 16'h95FB);
    for (int i = 0; i < len; i++) begin
      put(pl[i]);
      if (gapped) gap(1 + (i % 2));
    end
    put(bad ? (c ^ 16'h0100) : c);
    if (gapped) gap(2);
    put(16'h95FD);
    gap(3);
    if (bad) note_err();
    if (slow) begin
      chk(sq.size() == len, "R4 slow-control beat count", sq.size(), len);
      chk(dq.size() == 0, "R4 data output silent", dq.size(), 0);
    end else begin
      chk(dq.size() == len, "R3 data beat count", dq.size(), len);
      chk(sq.size() == 0, "R3 slow-control output silent", sq.size(), 0);
    end
    ok_w = 1; ok_l = 1; ok_e = 1;
    for (int i = 0; i < len; i++) begin
      logic [17:0] b;
      b = slow ? ((i < sq.size()) ? sq[i] : '0) : ((i < dq.size()) ? dq[i] : '0);
      if (b[15:0] != pl[i]) ok_w = 0;
      if (b[17] != (i == len - 1)) ok_l = 0;
      if (b[16] != (bad && i == len - 1)) ok_e = 0;
    end
    chk(ok_w, slow ? "R4 payload words" : "R3 payload words", len, len);
    chk(ok_l, "R5 last flag placement", ok_l, 1);
    chk(ok_e, "R6 CRC error flag", ok_e, 1);
    chk_cnt(gapped ? "R10 R9 counter after gapped packet" : "R9 counter after packet");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] c;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!data_valid && !sc_valid && !data_last && !data_err && !sc_last && !sc_err,
        "R1 outputs during reset", {data_valid, sc_valid}, 0);
    chk_cnt("R1 counter during reset");
    rst_n = 1'b1;
    gap(4);
    chk(!data_valid && !sc_valid, "R1 outputs after reset", {data_valid, sc_valid}, 0);
    chk_cnt("R1 counter after reset");

    // R2: stray words with no open packet
    dq.delete(); sq.delete();
    put(16'h95FD); put(16'h1234); put(16'h95FD); put(16'h0000);
    gap(3);
    chk(dq.size() == 0 && sq.size() == 0, "R2 idle words dropped", dq.size() + sq.size(), 0);
    chk_cnt("R2 counter unchanged");

    // R3: exact latency, payload A B
    c = ref_crc(ref_crc(16'hFFFF, 16'h0A0A), 16'h0B0B);
    put(16'h95FB); put(16'h0A0A); put(16'h0B0B); put(c);
    @(negedge clk);
    in_valid = 1'b1; in_word = 16'h95FD;
    chk(data_valid && data_word == 16'h0A0A && !data_last,
        "R3 first beat one clock after its second successor", data_word, 16'h0A0A);
    @(negedge clk);
    in_valid = 1'b0;
    chk(data_valid && data_word == 16'h0B0B && data_last && !data_err,
        "R5 last beat on end code", {data_last, data_err, data_word}, {2'b10, 16'h0B0B});
    gap(2);

    // R8: short packets
    dq.delete(); sq.delete();
    put(16'h95FB); put(16'h7777); put(16'h95FD); gap(3);
    note_err();
    chk(dq.size() == 0, "R8 one word packet yields no beat", dq.size(), 0);
    chk_cnt("R8 counter after one word packet");
    put(16'h951C); put(16'h95FD); gap(3);
    note_err();
    chk(sq.size() == 0, "R8 empty packet yields no beat", sq.size(), 0);
    chk_cnt("R8 counter after empty packet");

    // R7: abort by a new start code
    dq.delete(); sq.delete();
    c = ref_crc(16'hFFFF, 16'h4444);
    put(16'h95FB); put(16'h1111); put(16'h2222); put(16'h3333);
    put(16'h951C); put(16'h4444); put(c); put(16'h95FD); gap(3);
    note_err();
    chk(dq.size() == 2, "R7 aborted packet beat count", dq.size(), 2);
    if (dq.size() == 2) begin
      chk(dq[0] == {2'b00, 16'h1111}, "R7 first beat plain", dq[0], {2'b00, 16'h1111});
      chk(dq[1] == {2'b11, 16'h2222}, "R7 aborted last beat", dq[1], {2'b11, 16'h2222});
    end
    chk(sq.size() == 1 && sq[0] == {2'b10, 16'h4444}, "R7 new packet delivered",
        (sq.size() > 0) ? sq[0] : 18'h0, {2'b10, 16'h4444});
    chk_cnt("R7 counter after abort");

    // R3 R4 R5 R6 R9 R10 sweep
    for (int len = 1; len <= 12; len++)
      for (int t = 0; t < 2; t++)
        for (int b = 0; b < 2; b++)
          run_pkt(t[0], len, b[0], len[0]);

    // R9: ceiling reached and held
    chk(err_count == CNT_W'(CNT_MAX) && err_sticky, "R9 counter saturated",
        err_count, CNT_MAX);

    // R1: reset clears the counter and flag again
    @(negedge clk);
    rst_n = 1'b0;
    exp_err = 0; exp_sticky = 0;
    gap(2);
    chk_cnt("R1 counter cleared by reset");
    rst_n = 1'b1;
    gap(4);
    chk(!data_valid && !sc_valid, "R1 outputs idle after second reset",
        {data_valid, sc_valid}, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule